// File: doc/BRIEF.md
# Cross-Domain Single-Pulse Synchronizer

This block moves a one-cycle strobe from a source clock domain into a destination clock domain whose clock has no fixed relation to the source clock. The strobe is not sampled directly, because a destination flop could miss it or catch it twice. The source side keeps a level register instead, and each strobe inverts it. That level crosses the domain boundary through a chain of destination flops whose length is set at build time. In the destination domain, a final stage watches the synchronized level. Every change it sees becomes exactly one destination-cycle strobe.

Use it for events that are rare compared with both clocks: a completion flag, a "new sample ready" mark, a tick. The sender must leave enough room between strobes for each level change to reach the end of the chain before the next one arrives. Both domains share one asynchronous reset, which is active low.

Top module: `pulse_xdomain_sync`

## Requirements
- R1: While `rst_n` is low, `pulse_out` is 0. After `rst_n` is released, `pulse_out` stays 0 until a new strobe arrives, even if the source level was 1 before the reset.
- R2: On every `clk_src` rising edge where `pulse_in` is 1, the source-domain level register inverts. On every other `clk_src` edge it holds its value.
- R3: The `SYNC_STAGES` parameter sets how many destination flops the level passes through, with a default of 2 and a minimum of 2. The source level register drives the first of these flops directly, with no logic between them.
- R4: Each `pulse_out` strobe is high for exactly one `clk_dst` cycle.
- R5: Every accepted `pulse_in` strobe produces exactly one `pulse_out` strobe, and no output strobe appears without an input strobe. This holds when strobes are at least `SYNC_STAGES`+2 destination cycles apart.
- R6: `pulse_out` goes high on the (`SYNC_STAGES`+1)-th rising `clk_dst` edge after the `clk_src` edge that captured the input strobe.
- R7: R5 holds both when the source clock is faster than the destination clock and when it is slower.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source-domain clock, rising edge |
| clk_dst | input | 1 | Destination-domain clock, rising edge |
| rst_n | input | 1 | Asynchronous reset for both domains, active low |
| pulse_in | input | 1 | One-cycle strobe in the source domain |
| pulse_out | output | 1 | One-cycle strobe in the destination domain |

## Verification
The bench builds two copies side by side, one with `SYNC_STAGES` = 2 and one with 4, and drives both from the same stimulus. The deeper copy checks that the latency tracks the parameter and sets the minimum strobe spacing. The destination clock period is 10, and the source period is switched between 7 and 23, so both the fast-to-slow and slow-to-fast directions are covered. The source edges are offset by a fraction of a unit, so they never line up with destination edges. The gap between strobes is swept over eight values in each direction, which walks the capture point across many relative clock phases, and the latency of each output strobe is computed from timestamps. A reset applied while the source level sits at 1 exposes any register that fails to clear.

// File: rtl/pxs_pkg.sv
`timescale 1ns/100ps
package pxs_pkg;

  // Next value of the source level given the current strobe.
  function automatic logic level_after(input logic level, input logic strobe);
    return strobe ? ~level : level;
  endfunction

  // A change between two consecutive samples of the synchronized level.
  function automatic logic level_moved(input logic now_v, input logic before_v);
    return now_v != before_v;
  endfunction

endpackage

// File: rtl/pxs_src_level.sv
`timescale 1ns/100ps
module pxs_src_level
  import pxs_pkg::*;
(
  input  logic clk_src,
  input  logic rst_n,
  input  logic strobe_i,
  output logic level_o
);

  logic level_q;

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_after(level_q, strobe_i);
  end

  // Registered output, straight into the first destination flop.
  assign level_o = level_q;

  p_level_flips_r2: assert property (@(posedge clk_src) disable iff (!rst_n)
    strobe_i |=> (level_q != $past(level_q)));

  p_level_holds_r2: assert property (@(posedge clk_src) disable iff (!rst_n)
    !strobe_i |=> $stable(level_q));

endmodule

// File: rtl/pxs_sync_chain.sv
`timescale 1ns/100ps
module pxs_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk_dst,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] stage_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_head
        always_ff @(posedge clk_dst or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= 1'b0;
          else        stage_q[0] <= async_i;
        end
      end else begin : g_tail
        always_ff @(posedge clk_dst or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= 1'b0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[LAST];

  // With legal strobe spacing the level has settled before it leaves the chain.
  p_chain_settled_r3: assert property (@(posedge clk_dst) disable iff (!rst_n)
    !$stable(sync_o) |-> (sync_o == async_i));

endmodule

// File: rtl/pxs_edge_pulse.sv
`timescale 1ns/100ps
module pxs_edge_pulse
  import pxs_pkg::*;
(
  input  logic clk_dst,
  input  logic rst_n,
  input  logic level_i,
  output logic pulse_o
);

  logic seen_q;
  logic pulse_q;
  logic level_change;

  assign level_change = level_moved(level_i, seen_q);

  always_ff @(posedge clk_dst or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      seen_q  <= level_i;
      pulse_q <= level_change;
    end
  end

  assign pulse_o = pulse_q;

  p_one_cycle_r4: assert property (@(posedge clk_dst) disable iff (!rst_n)
    pulse_o |=> !pulse_o);

  always @(posedge clk_dst) begin
    if (!rst_n) p_reset_quiet_r1: assert (pulse_o == 1'b0);
  end

endmodule

// File: rtl/pulse_xdomain_sync.sv
`timescale 1ns/100ps
module pulse_xdomain_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_src,
  input  logic clk_dst,
  input  logic rst_n,
  input  logic pulse_in,
  output logic pulse_out
);

  logic src_level;
  logic dst_level;

  pxs_src_level u_src (
    .clk_src (clk_src),
    .rst_n   (rst_n),
    .strobe_i(pulse_in),
    .level_o (src_level)
  );

  pxs_sync_chain #(.STAGES(SYNC_STAGES)) u_chain (
    .clk_dst(clk_dst),
    .rst_n  (rst_n),
    .async_i(src_level),
    .sync_o (dst_level)
  );

  pxs_edge_pulse u_edge (
    .clk_dst(clk_dst),
    .rst_n  (rst_n),
    .level_i(dst_level),
    .pulse_o(pulse_out)
  );

endmodule

// File: tb/sim_pulse_xdomain_sync.sv
`timescale 1ns/100ps
module sim_pulse_xdomain_sync;

  localparam int  DST_PERIOD = 10;
  localparam int  DEPTH_A    = 2;
  localparam int  DEPTH_B    = 4;
  localparam real SRC_OFFSET = 1.3;

  logic clk_src  = 1'b0;
  logic clk_dst  = 1'b0;
  logic rst_n    = 1'b0;
  logic pulse_in = 1'b0;
  logic [1:0] pout;
  logic [1:0] prev_out = 2'b00;

  real src_half = 3.5;
  int  n_checks = 0, n_fail = 0;
  int  mon_checks = 0, mon_fail = 0;
  int  cap_cnt = 0;
  real t_cap = 0.0;
  int  out_cnt [2] = '{0, 0};

  initial begin
    #(SRC_OFFSET);
    forever #(src_half) clk_src = ~clk_src;
  end

  initial forever #(DST_PERIOD/2) clk_dst = ~clk_dst;

  pulse_xdomain_sync #(.SYNC_STAGES(DEPTH_A)) u0 (
    .clk_src(clk_src), .clk_dst(clk_dst), .rst_n(rst_n),
    .pulse_in(pulse_in), .pulse_out(pout[0]));

  pulse_xdomain_sync #(.SYNC_STAGES(DEPTH_B)) u1 (
    .clk_src(clk_src), .clk_dst(clk_dst), .rst_n(rst_n),
    .pulse_in(pulse_in), .pulse_out(pout[1]));

  // Record every strobe the source side captures (R2 increments the level).
  always @(posedge clk_src) begin
    if (rst_n && pulse_in) begin
      cap_cnt <= cap_cnt + 1;
      t_cap   <= $realtime;
    end
  end

  // Destination rising edges lie at DST_PERIOD/2 + k*DST_PERIOD.
  function automatic int dst_edges_between(real a, real b);
    real ofs;
    ofs = DST_PERIOD / 2.0;
    return int'($floor((b - ofs) / DST_PERIOD)) - int'($floor((a - ofs) / DST_PERIOD));
  endfunction

  always @(negedge clk_dst) begin
    for (int i = 0; i < 2; i++) begin
      int depth;
      int lat;
      depth = (i == 0) ? DEPTH_A : DEPTH_B;
      if (prev_out[i]) begin
        mon_checks++;
        if (pout[i]) begin
          mon_fail++;
          $display("FAIL R4 inst %0d width: actual high>1 cycle (%0d) expected %0d", i, 2, 1);
        end
      end else if (pout[i]) begin
        out_cnt[i]++;
        mon_checks++;
        if (out_cnt[i] > cap_cnt) begin
          mon_fail++;
          $display("FAIL R5 inst %0d spurious: actual outputs %0d expected <= %0d", i, out_cnt[i], cap_cnt);
        end
        lat = dst_edges_between(t_cap, $realtime);
        mon_checks++;
        if (lat != depth + 1) begin
          mon_fail++;
          $display("FAIL R6 inst %0d latency: actual %0d expected %0d", i, lat, depth + 1);
        end
      end
    end
    prev_out = pout;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_pulse();
    @(negedge clk_src) pulse_in = 1'b1;
    @(negedge clk_src) pulse_in = 1'b0;
  endtask

  task automatic settle();
    repeat (12) @(negedge clk_dst);
  endtask

  task automatic quiet_window(input int n, input string req);
    int seen0 = 0, seen1 = 0;
    repeat (n) begin
      @(negedge clk_dst);
      if (pout[0]) seen0++;
      if (pout[1]) seen1++;
    end
    check(seen0 == 0, req, seen0, 0);
    check(seen1 == 0, req, seen1, 0);
  endtask

  task automatic check_counts(input string req);
    check(out_cnt[0] == cap_cnt, req, out_cnt[0], cap_cnt);
    check(out_cnt[1] == cap_cnt, req, out_cnt[1], cap_cnt);
  endtask

  initial begin
    repeat (4) @(negedge clk_dst);
    check(pout == 2'b00, "R1 output during reset", int'(pout), 0);
    rst_n = 1'b1;
    quiet_window(20, "R1 quiet after release");

    // Fast source (period 7) into slower destination (period 10): R7.
    for (int g = 10; g < 18; g++) begin
      send_pulse();
      repeat (g) @(negedge clk_src);
    end
    settle();
    check(cap_cnt == 8, "R2 strobes captured fast source", cap_cnt, 8);
    check_counts("R5 R7 fast source count");

    // Slow source (period 23) into faster destination: R7.
    src_half = 11.5;
    repeat (3) @(negedge clk_src);
    for (int g = 4; g < 12; g++) begin
      send_pulse();
      repeat (g) @(negedge clk_src);
    end
    settle();
    check(cap_cnt == 16, "R2 strobes captured slow source", cap_cnt, 16);
    check_counts("R5 R7 slow source count");

    // Odd total leaves the source level at 1; reset must clear everything (R1).
    send_pulse();
    settle();
    check_counts("R5 odd strobe count");
    @(negedge clk_dst) rst_n = 1'b0;
    repeat (3) @(negedge clk_dst);
    check(pout == 2'b00, "R1 output during mid reset", int'(pout), 0);
    rst_n = 1'b1;
    quiet_window(30, "R1 no pulse after reset with level set");

    send_pulse();
    settle();
    check_counts("R5 count after reset");
    check(cap_cnt == 18, "R3 both depths saw every strobe", cap_cnt, 18);

    $display("End of test - %0d assertions evaluated, %0d failures",
             n_checks + mon_checks, n_fail + mon_fail);
    $finish;
  end

  initial begin
    #(60000 * DST_PERIOD);
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_checks + mon_checks + 1, n_fail + mon_fail + 1);
    $finish;
  end

endmodule